// File: doc/BRIEF.md
# Endpoint Interrupt Source Arbiter

This block watches the completion flags of a set of endpoint or channel slots and names the one that software should service next. Each slot supplies a receive-complete flag, a transmit-complete flag and a class bit. The class bit marks the slot as isochronous or double-buffered bulk. A slot with either completion flag set is pending. The block selects a winner from the pending slots, registers its index and its transfer direction, and drives a summary interrupt that is high while anything is pending.

The priority has two tiers. Pending slots whose class bit is set beat every other pending slot. Inside a tier, the lowest slot index wins. The direction output shows receive whenever the winner's receive flag is set, even if its transmit flag is also set. It shows transmit only when the transmit flag is the winner's sole flag. The flags belong to the surrounding endpoint logic. Once software clears the winner's flag, the next pending slot appears one cycle later.

The block also holds a low-power-request status bit. Hardware sets it when a link-sleep entry request is accepted. Software clears it by writing 0, and a software write of 1 leaves it unchanged.

Top module: `ep_irq_arbiter`

## Requirements
- R1: `irq` is a registered copy of the condition "some slot has `rx_done` or `tx_done` set", taken from the previous clock edge.
- R2: While `irq` is high, `win_id` names a slot that was pending at the previous edge.
- R3: If any pending slot has its `prio_type` bit set, the winner is one of those slots, whatever the other slots show.
- R4: Within the tier the winner comes from, no slot with a lower index is pending. Slot 0 ranks highest.
- R5: `win_dir` is 1 when the winner's `rx_done` is set, with or without its `tx_done`.
- R6: `win_dir` is 0 when the winner has only `tx_done` set.
- R7: With no slot pending, the next edge gives `win_id` = 0, `win_dir` = 0 and `irq` = 0.
- R8: The outputs follow the flags with one cycle of latency. After the winner's flags drop, the following cycle shows the next pending slot.
- R9: `lpm_accept` high at an edge makes `lpm_req` 1 after that edge.
- R10: A write (`lpm_wr` = 1) with `lpm_wdata` = 0 clears `lpm_req`. A write with `lpm_wdata` = 1 leaves it unchanged.
- R11: When `lpm_accept` and a clearing write come at the same edge, `lpm_req` ends up 1.
- R12: With `rst_n` low at an edge, `win_id`, `win_dir`, `irq` and `lpm_req` become 0 at that edge, whatever the inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_done | input | NUM_SLOTS | Receive-complete flag per slot |
| tx_done | input | NUM_SLOTS | Transmit-complete flag per slot |
| prio_type | input | NUM_SLOTS | 1 = isochronous or double-buffered bulk slot (upper tier) |
| lpm_accept | input | 1 | Pulse: a link-sleep entry request was accepted |
| lpm_wr | input | 1 | Software write strobe for the low-power-request bit |
| lpm_wdata | input | 1 | Data for that write; only 0 has an effect |
| win_id | output | log2(NUM_SLOTS) | Index of the winning slot |
| win_dir | output | 1 | 1 = receive (OUT) pending on the winner, 0 = transmit only (IN) |
| irq | output | 1 | Summary interrupt: some slot is pending |
| lpm_req | output | 1 | Low-power-request status bit |

## Verification
Two events can fall on the same edge: a hardware set of the low-power-request bit and a software write of 0 to that bit. The bench drives `lpm_accept` and a clearing write together and expects the bit to read 1 afterwards. It then clears the bit with a lone write of 0 to show that the write path works by itself. Two selection events can also fall on the same edge: the flags of the winner drop while a lower-tier slot and a higher-tier slot stay pending. The bench checks that the very next cycle shows the higher-tier slot.

// File: rtl/ep_arb_pkg.sv
// Package ep_arb_pkg
// Shared constants and the direction encoding for the endpoint interrupt
// source arbiter. Assumes slot counts are powers of two up to 16.
package ep_arb_pkg;
    localparam int unsigned DEF_SLOTS = 16;

    // Direction of the winning slot's pending transaction.
    typedef enum logic {
        DIR_IN  = 1'b0,   // only transmit-complete pending
        DIR_OUT = 1'b1    // receive-complete pending (possibly both)
    } dir_e;
endpackage

// File: rtl/ep_arb_pick.sv
// Module ep_arb_pick
// Finds the lowest set bit of a request vector and reports its index.
// Assumes N >= 2. When no bit is set, found is 0 and idx is 0.
module ep_arb_pick #(
    parameter int unsigned N = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set index is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

    // Any request present.
    assign found = |req;
endmodule

// File: rtl/ep_arb_lpm_bit.sv
// Module ep_arb_lpm_bit
// Low-power-request status bit. Hardware sets it; software may clear it
// by writing 0; writing 1 has no effect. A hardware set and a clearing
// write at the same edge leave the bit set so no request is lost.
module ep_arb_lpm_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic q
);
    // Hold, set, or clear the status bit; set has precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (wr_i && !wdata_i) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/ep_arb_out_reg.sv
// Module ep_arb_out_reg
// Output register stage for the selection result. Assumes the combined
// selection is already forced to zero when nothing is pending.
module ep_arb_out_reg #(
    parameter int unsigned IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     id_d,
    input  ep_arb_pkg::dir_e  dir_d,
    input  logic              irq_d,
    output logic [IW-1:0]     id_q,
    output ep_arb_pkg::dir_e  dir_q,
    output logic              irq_q
);
    // Capture the winner, its direction and the summary each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            dir_q <= ep_arb_pkg::DIR_IN;
            irq_q <= 1'b0;
        end else begin
            id_q  <= id_d;
            dir_q <= dir_d;
            irq_q <= irq_d;
        end
    end
endmodule

// File: rtl/ep_irq_arbiter.sv
// Module ep_irq_arbiter
// Selects the next slot to service from per-slot completion flags using a
// two-tier priority (class bit set first, then the rest; lowest index wins
// within a tier), registers the winner's index and direction, and drives a
// summary interrupt. Also holds the low-power-request status bit.
// Assumes flags are synchronous to clk and owned by the endpoint logic.
module ep_irq_arbiter #(
    parameter int unsigned NUM_SLOTS = ep_arb_pkg::DEF_SLOTS,
    localparam int unsigned ID_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] rx_done,
    input  logic [NUM_SLOTS-1:0] tx_done,
    input  logic [NUM_SLOTS-1:0] prio_type,
    input  logic                 lpm_accept,
    input  logic                 lpm_wr,
    input  logic                 lpm_wdata,
    output logic [ID_W-1:0]      win_id,
    output logic                 win_dir,
    output logic                 irq,
    output logic                 lpm_req
);
    logic [NUM_SLOTS-1:0] pend;
    logic [NUM_SLOTS-1:0] hi_req;
    logic [NUM_SLOTS-1:0] lo_req;
    logic                 hi_found;
    logic                 lo_found;
    logic [ID_W-1:0]      hi_idx;
    logic [ID_W-1:0]      lo_idx;
    logic [ID_W-1:0]      sel_id;
    ep_arb_pkg::dir_e     sel_dir;
    ep_arb_pkg::dir_e     dir_q;

    // Per-slot pending and tier split.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign pend[g]   = rx_done[g] | tx_done[g];
        assign hi_req[g] = pend[g] & prio_type[g];
        assign lo_req[g] = pend[g] & ~prio_type[g];
    end

    ep_arb_pick #(.N(NUM_SLOTS)) u_pick_hi (
        .req   (hi_req),
        .found (hi_found),
        .idx   (hi_idx)
    );

    ep_arb_pick #(.N(NUM_SLOTS)) u_pick_lo (
        .req   (lo_req),
        .found (lo_found),
        .idx   (lo_idx)
    );

    // Merge the tiers and derive the winner's direction.
    always_comb begin
        sel_id  = '0;
        sel_dir = ep_arb_pkg::DIR_IN;
        if (hi_found) begin
            sel_id = hi_idx;
        end else if (lo_found) begin
            sel_id = lo_idx;
        end
        if ((hi_found || lo_found) && rx_done[sel_id]) begin
            sel_dir = ep_arb_pkg::DIR_OUT;
        end
    end

    ep_arb_out_reg #(.IW(ID_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .id_d  (sel_id),
        .dir_d (sel_dir),
        .irq_d (hi_found | lo_found),
        .id_q  (win_id),
        .dir_q (dir_q),
        .irq_q (irq)
    );

    assign win_dir = (dir_q == ep_arb_pkg::DIR_OUT);

    ep_arb_lpm_bit u_lpm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (lpm_accept),
        .wr_i    (lpm_wr),
        .wdata_i (lpm_wdata),
        .q       (lpm_req)
    );
endmodule

// File: rtl/ep_irq_arbiter_chk.sv
// Module ep_irq_arbiter_chk
// Checker bound to ep_irq_arbiter: relates registered outputs to the
// flags seen at the previous edge. Assumes the default one-cycle latency.
module ep_irq_arbiter_chk #(
    parameter int unsigned NUM_SLOTS = 16,
    localparam int unsigned ID_W = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] rx_done,
    input logic [NUM_SLOTS-1:0] tx_done,
    input logic [NUM_SLOTS-1:0] prio_type,
    input logic                 lpm_accept,
    input logic                 lpm_wr,
    input logic                 lpm_wdata,
    input logic [ID_W-1:0]      win_id,
    input logic                 win_dir,
    input logic                 irq,
    input logic                 lpm_req
);
    localparam logic [NUM_SLOTS-1:0] ONE = NUM_SLOTS'(1);

    logic [NUM_SLOTS-1:0] pend_c;
    logic [NUM_SLOTS-1:0] win_bit;
    logic [NUM_SLOTS-1:0] below;
    assign pend_c  = rx_done | tx_done;
    assign win_bit = ONE << win_id;
    assign below   = win_bit - ONE;

    AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|pend_c))); // R1
    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq) |-> (($past(pend_c) & win_bit) != '0)); // R2
    AST_UPPER_TIER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(pend_c & prio_type) != '0))
        |-> (($past(prio_type) & win_bit) != '0)); // R3
    AST_LOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq)
        |-> (($past(pend_c) & below &
              ($past(prio_type) & win_bit ? $past(prio_type) : ~$past(prio_type))) == '0)); // R4
    AST_DIR_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq) |-> (win_dir == (($past(rx_done) & win_bit) != '0))); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !irq) |-> (win_id == '0 && !win_dir)); // R7
    AST_LPM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lpm_accept)) |-> lpm_req); // R9
    AST_LPM_WR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lpm_wr && lpm_wdata && !lpm_accept))
        |-> (lpm_req == $past(lpm_req))); // R10
endmodule

bind ep_irq_arbiter ep_irq_arbiter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_done    (rx_done),
    .tx_done    (tx_done),
    .prio_type  (prio_type),
    .lpm_accept (lpm_accept),
    .lpm_wr     (lpm_wr),
    .lpm_wdata  (lpm_wdata),
    .win_id     (win_id),
    .win_dir    (win_dir),
    .irq        (irq),
    .lpm_req    (lpm_req)
);

// File: tb/sim_ep_irq_arbiter.sv
// Directed bench for ep_irq_arbiter: one task per scenario, each checking
// its own results against a priority model built from the requirements.
module sim_ep_irq_arbiter;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  rx_done = '0;
    logic [N-1:0]  tx_done = '0;
    logic [N-1:0]  prio_type = '0;
    logic          lpm_accept = 1'b0;
    logic          lpm_wr = 1'b0;
    logic          lpm_wdata = 1'b0;
    logic [3:0]    win_id;
    logic          win_dir;
    logic          irq;
    logic          lpm_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    ep_irq_arbiter #(.NUM_SLOTS(N)) u0 (
        .clk (clk), .rst_n (rst_n),
        .rx_done (rx_done), .tx_done (tx_done), .prio_type (prio_type),
        .lpm_accept (lpm_accept), .lpm_wr (lpm_wr), .lpm_wdata (lpm_wdata),
        .win_id (win_id), .win_dir (win_dir), .irq (irq), .lpm_req (lpm_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model: expected id/dir/irq for a flag pattern.
    task automatic model(input logic [N-1:0] rx, input logic [N-1:0] tx,
                         input logic [N-1:0] ty, output int id, output int dir,
                         output int any);
        logic [N-1:0] p;
        p = rx | tx;
        id = 0; dir = 0; any = (p != 0);
        for (int i = N - 1; i >= 0; i--) if (p[i] && !ty[i]) id = i;
        if ((p & ty) != 0)
            for (int i = N - 1; i >= 0; i--) if (p[i] && ty[i]) id = i;
        if (any != 0) dir = rx[id];
    endtask

    // Drive flags at a falling edge; the next falling edge shows the result.
    task automatic apply_and_check(input logic [N-1:0] rx, input logic [N-1:0] tx,
                                   input logic [N-1:0] ty, input string req);
        int id, dir, any;
        rx_done = rx; tx_done = tx; prio_type = ty;
        @(negedge clk);
        model(rx, tx, ty, id, dir, any);
        chk(int'(irq) == any, {req, " irq"}, int'(irq), any);
        chk(int'(win_id) == id, {req, " win_id"}, int'(win_id), id);
        chk(int'(win_dir) == dir, {req, " win_dir"}, int'(win_dir), dir);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        rx_done = 16'h8421; tx_done = 16'h00F0; prio_type = 16'hFFFF; lpm_accept = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(win_id == 0 && !win_dir && !irq, "R12 outputs", int'(win_id), 0);
        chk(!lpm_req, "R12 lpm_req", int'(lpm_req), 0);
        lpm_accept = 1'b0; rx_done = '0; tx_done = '0; prio_type = '0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle();
        apply_and_check('0, '0, 16'hFFFF, "R7 idle");
    endtask

    task automatic t_tiers();
        // slot 1 low tier, slot 9 upper tier -> 9 (R3)
        apply_and_check(16'h0002, 16'h0200, 16'h0200, "R3 tier");
        // upper tier slots 5 and 12, low tier 0 -> 5 (R3, R4)
        apply_and_check(16'h1001, 16'h0020, 16'h1020, "R3_R4 mixed");
    endtask

    task automatic t_lowidx();
        apply_and_check(16'h0000, 16'h8108, 16'h0000, "R4 low index");
        apply_and_check(16'h8000, 16'h0000, 16'h0000, "R2 top slot");
    endtask

    task automatic t_dir();
        apply_and_check(16'h0010, 16'h0010, 16'h0000, "R5 both flags");
        apply_and_check(16'h0040, 16'h0000, 16'h0000, "R5 rx only");
        apply_and_check(16'h0000, 16'h0040, 16'h0000, "R6 tx only");
    endtask

    task automatic t_clear_next();
        // winner slot 3 (upper); slot 0 lower and slot 7 upper remain
        apply_and_check(16'h0008, 16'h0081, 16'h0088, "R8 before clear");
        apply_and_check(16'h0000, 16'h0081, 16'h0088, "R8 next upper");
        apply_and_check(16'h0000, 16'h0001, 16'h0088, "R8 next lower");
        apply_and_check(16'h0000, 16'h0000, 16'h0088, "R8 R7 drained");
    endtask

    task automatic t_random();
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] rx, tx, ty;
            rx = N'($urandom & $urandom & $urandom);
            tx = N'($urandom & $urandom);
            ty = N'($urandom);
            apply_and_check(rx, tx, ty, "R1_R3_R4_R5 random");
        end
    endtask

    task automatic t_lpm();
        lpm_accept = 1'b1; @(negedge clk); lpm_accept = 1'b0;
        chk(lpm_req, "R9 set", int'(lpm_req), 1);
        lpm_wr = 1'b1; lpm_wdata = 1'b1; @(negedge clk); lpm_wr = 1'b0;
        chk(lpm_req, "R10 write one", int'(lpm_req), 1);
        lpm_wr = 1'b1; lpm_wdata = 1'b0; @(negedge clk); lpm_wr = 1'b0;
        chk(!lpm_req, "R10 write zero", int'(lpm_req), 0);
        lpm_wr = 1'b1; lpm_wdata = 1'b1; @(negedge clk); lpm_wr = 1'b0;
        chk(!lpm_req, "R10 write one from clear", int'(lpm_req), 0);
        lpm_accept = 1'b1; lpm_wr = 1'b1; lpm_wdata = 1'b0;
        @(negedge clk);
        lpm_accept = 1'b0; lpm_wr = 1'b0;
        chk(lpm_req, "R11 set beats clear", int'(lpm_req), 1);
        lpm_wr = 1'b1; lpm_wdata = 1'b0; @(negedge clk); lpm_wr = 1'b0;
        chk(!lpm_req, "R10 clear after R11", int'(lpm_req), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_tiers();
        t_lowidx();
        t_dir();
        t_clear_next();
        t_lpm();
        t_random();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog R1: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule